// File: doc/BRIEF.md
# PCI Command Register with Parity-Error Reporting

This block holds the 16-bit command word of a PCI function's configuration header, located at dword offset 04h. It also turns parity-error detections into the error signals and status-set strobes that the command word enables. The host updates the word through a simple configuration access port. That port carries a byte address, a write strobe, four byte enables and 32-bit write data, and it returns read data combinationally. Only a few bits of the word can be written. Every other bit is tied to zero.

Four enables are decoded from the word: bus mastering, memory decode, I/O decode and parity response. The first three feed the rest of the device as gating signals. The parity-response and system-error enables decide which outputs an error produces. Each error can raise the detected-parity status strobe, the data-parity status strobe, the PERR# request pulse and the SERR# request pulse, depending on those enables. Each of these outputs is a one-cycle pulse, registered from the strobe sampled at the previous edge.

The block has two resets. The asynchronous hard reset clears the whole word. The synchronous soft reset leaves the word as it is and only discards error reporting for the cycle it is held.

Top module: `pci_cmd_reg`

## Requirements
- R1: Only bits 8, 6, 2, 1 and 0 of the command word can be written. These are the system-error enable, parity-response enable, bus-master enable, memory enable and I/O enable. Bits 15:9, 7, 5, 4 and 3 always read zero, whatever is written to them.
- R2: A write goes to the command word only when `cfg_addr` equals 04h. On such a write, `cfg_be[0]` gates bits 7:0 and `cfg_be[1]` gates bits 15:8, so the upper lane can change only bit 8. A read at 04h returns the word in `cfg_rdata[15:0]` with zero above it. A read at any other address returns zero.
- R3: Hard reset (`hard_rst_n` low, asynchronous) clears the command word, all enable outputs and all pulse outputs.
- R4: Soft reset (`soft_rst` high at a clock edge) leaves the command word unchanged. It forces every pulse output low in the following cycle.
- R5: `bm_en`, `mem_en` and `io_en` follow bits 2, 1 and 0. The new values take effect from the edge that writes them. Writing zero to the word drops all three.
- R6: A data parity error strobe sampled while bit 6 is 1 gives a one-cycle `perr_pulse` in the next cycle. While bit 6 is 0, no `perr_pulse` is produced.
- R7: `stat_dataperr_set` pulses only for a data parity error sampled while bit 6 is 1 and `master_cycle` is 1.
- R8: An address parity error produces `serr_pulse` and `stat_serr_set` only if bits 8 and 6 are both 1.
- R9: `stat_det_perr_set` pulses for any sampled address or data parity error, whatever the enables are.
- R10: An error output is judged against the command word as it stood before the edge that samples the error. A write at that same edge does not affect that error's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cfg_addr | input | ADDR_W | Configuration byte address (dword aligned) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| addr_perr_det | input | 1 | Address parity error detected |
| data_perr_det | input | 1 | Data parity error detected |
| master_cycle | input | 1 | 1 when the current cycle is a master cycle |
| perr_pulse | output | 1 | Request to drive PERR# |
| serr_pulse | output | 1 | Request to drive SERR# |
| stat_det_perr_set | output | 1 | Set strobe for the detected-parity status bit |
| stat_dataperr_set | output | 1 | Set strobe for the data-parity status bit |
| stat_serr_set | output | 1 | Set strobe for the signaled-system-error status bit |
| bm_en | output | 1 | Bus-master enable |
| mem_en | output | 1 | Memory decode enable |
| io_en | output | 1 | I/O decode enable |

## Verification
Results come due at three different times. A write changes the command word, and with it the enables and `cfg_rdata`, at the edge that samples it. The read path is combinational, so `cfg_rdata` is valid as soon as the address settles. Error pulses appear one edge after their strobe and are computed from the word as it stood before that edge. The bench drives inputs at the falling edge and samples 1 ns after the rising edge. Its model computes expected pulses from the word held before the edge and only then applies the write, which keeps R10 coherent under random writes that coincide with errors.

// File: rtl/pci_cmd_reg.sv
module pci_cmd_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_OFF = 'h04,
  parameter logic [15:0] WMASK = 16'h0147
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              addr_perr_det,
  input  logic              data_perr_det,
  input  logic              master_cycle,
  output logic              perr_pulse,
  output logic              serr_pulse,
  output logic              stat_det_perr_set,
  output logic              stat_dataperr_set,
  output logic              stat_serr_set,
  output logic              bm_en,
  output logic              mem_en,
  output logic              io_en
);
  localparam int SERREN_B = 8;
  localparam int PERREN_B = 6;
  localparam int BMEN_B   = 2;
  localparam int MEMEN_B  = 1;
  localparam int IOEN_B   = 0;

  logic [15:0] cmd_q;
  logic        hit;
  logic        par_rsp, sys_rsp;

  assign hit     = (cfg_addr == CMD_OFF);
  assign par_rsp = cmd_q[PERREN_B];
  assign sys_rsp = cmd_q[SERREN_B] & cmd_q[PERREN_B];

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      cmd_q <= '0;
    end else if (cfg_wr && hit) begin
      if (cfg_be[0]) cmd_q[7:0]  <= cfg_wdata[7:0]  & WMASK[7:0];
      if (cfg_be[1]) cmd_q[15:8] <= cfg_wdata[15:8] & WMASK[15:8];
    end
  end

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      perr_pulse        <= 1'b0;
      serr_pulse        <= 1'b0;
      stat_det_perr_set <= 1'b0;
      stat_dataperr_set <= 1'b0;
      stat_serr_set     <= 1'b0;
    end else if (soft_rst) begin
      perr_pulse        <= 1'b0;
      serr_pulse        <= 1'b0;
      stat_det_perr_set <= 1'b0;
      stat_dataperr_set <= 1'b0;
      stat_serr_set     <= 1'b0;
    end else begin
      perr_pulse        <= data_perr_det & par_rsp;
      stat_dataperr_set <= data_perr_det & par_rsp & master_cycle;
      serr_pulse        <= addr_perr_det & sys_rsp;
      stat_serr_set     <= addr_perr_det & sys_rsp;
      stat_det_perr_set <= addr_perr_det | data_perr_det;
    end
  end

  assign cfg_rdata = hit ? {16'h0000, cmd_q} : 32'h0;
  assign bm_en     = cmd_q[BMEN_B];
  assign mem_en    = cmd_q[MEMEN_B];
  assign io_en     = cmd_q[IOEN_B];
endmodule

module pci_cmd_reg_chk (
  input logic        clk,
  input logic        hard_rst_n,
  input logic        soft_rst,
  input logic        cfg_wr,
  input logic [31:0] cfg_rdata,
  input logic        addr_perr_det,
  input logic        data_perr_det,
  input logic        master_cycle,
  input logic        perr_pulse,
  input logic        serr_pulse,
  input logic        stat_det_perr_set,
  input logic        stat_dataperr_set,
  input logic        stat_serr_set,
  input logic [15:0] cmd_q
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (cfg_rdata & 32'hFFFF_FEB8) == 32'h0);

  // R4
  soft_keep_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (soft_rst && !cfg_wr) |=> cmd_q == $past(cmd_q));

  // R4
  soft_quiet_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    soft_rst |=> !(perr_pulse || serr_pulse || stat_det_perr_set));

  // R6
  perr_cause_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $rose(perr_pulse) |-> $past(data_perr_det && cmd_q[6]));

  // R7
  dataperr_with_perr_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    stat_dataperr_set |-> perr_pulse);

  // R8
  serr_cause_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $rose(serr_pulse) |-> $past(addr_perr_det && cmd_q[8] && cmd_q[6]));

  // R9
  det_cover_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (perr_pulse || serr_pulse) |-> stat_det_perr_set);
endmodule

bind pci_cmd_reg pci_cmd_reg_chk u_chk (.*);

// File: tb/pci_cmd_reg_bench.sv
module pci_cmd_reg_bench;
  logic clk = 1'b0;
  logic hard_rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [7:0] cfg_addr = 8'h04;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic addr_perr_det = 1'b0, data_perr_det = 1'b0, master_cycle = 1'b0;
  logic perr_pulse, serr_pulse, stat_det_perr_set, stat_dataperr_set, stat_serr_set;
  logic bm_en, mem_en, io_en;

  int checks = 0, errors = 0;
  logic [15:0] m = 16'h0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_cmd_reg u_pci_cmd_reg (.*);

  function automatic logic [15:0] apply_wr(logic [15:0] cur, logic [3:0] be, logic [31:0] d);
    logic [15:0] n = cur;
    if (be[0]) n[7:0] = d[7:0] & 8'h47;
    if (be[1]) n[15:8] = d[15:8] & 8'h01;
    return n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [7:0] a, logic we, logic [3:0] be, logic [31:0] d,
                     logic ap, logic dp, logic ms, logic sr);
    logic ep, es, ed, edp;
    @(negedge clk);
    cfg_addr = a; cfg_wr = we; cfg_be = be; cfg_wdata = d;
    addr_perr_det = ap; data_perr_det = dp; master_cycle = ms; soft_rst = sr;
    @(posedge clk); #1;
    // R10: expectations use the word held before this edge
    ep  = !sr && dp && m[6];
    edp = ep && ms;
    es  = !sr && ap && m[8] && m[6];
    ed  = !sr && (ap || dp);
    if (we && a == 8'h04) m = apply_wr(m, be, d);
    chk("R6 perr_pulse", perr_pulse, ep);
    chk("R7 stat_dataperr_set", stat_dataperr_set, edp);
    chk("R8 serr_pulse", serr_pulse, es);
    chk("R8 stat_serr_set", stat_serr_set, es);
    chk("R9 stat_det_perr_set", stat_det_perr_set, ed);
    chk("R2 cfg_rdata", cfg_rdata, (a == 8'h04) ? {16'h0, m} : 32'h0);
    chk("R5 enables", {bm_en, mem_en, io_en}, {m[2], m[1], m[0]});
  endtask

  task automatic hard_reset();
    @(negedge clk);
    hard_rst_n = 1'b0; cfg_addr = 8'h04; cfg_wr = 1'b0;
    addr_perr_det = 1'b0; data_perr_det = 1'b0; soft_rst = 1'b0;
    #1;
    m = 16'h0;
    chk("R3 word after hard reset", cfg_rdata, 32'h0);
    chk("R3 outputs after hard reset",
        {perr_pulse, serr_pulse, stat_det_perr_set, stat_dataperr_set, stat_serr_set, bm_en, mem_en, io_en}, 0);
    @(negedge clk);
    hard_rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    hard_reset();
    // R1: all ones reads back only the writable bits
    cyc(8'h04, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    chk("R1 writable mask", cfg_rdata, 32'h0000_0147);
    // R5: zero write drops every enable
    cyc(8'h04, 1, 4'hF, 32'h0, 0, 0, 0, 0);
    chk("R5 zero write", {bm_en, mem_en, io_en}, 3'b000);
    // R2: upper lane only changes bit 8
    cyc(8'h04, 1, 4'h2, 32'hFFFF_FFFF, 0, 0, 0, 0);
    chk("R2 upper lane", cfg_rdata, 32'h0000_0100);
    // R2: other address has no effect
    cyc(8'h08, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cyc(8'h04, 0, 4'h0, 32'h0, 0, 0, 0, 0);
    chk("R2 other address ignored", cfg_rdata, 32'h0000_0100);
    // R8: SERR needs parity response too
    cyc(8'h04, 0, 4'h0, 32'h0, 1, 0, 0, 0);
    cyc(8'h04, 0, 4'h0, 32'h0, 0, 0, 0, 0);
    chk("R8 serren alone", serr_pulse, 0);
    // R6/R9: parity response off gives only detected strobe
    cyc(8'h04, 0, 4'h0, 32'h0, 0, 1, 1, 0);
    cyc(8'h04, 1, 4'h1, 32'h0000_0040, 1, 1, 1, 0);
    cyc(8'h04, 0, 4'h0, 32'h0, 1, 1, 0, 0);
    chk("R8 both enables", serr_pulse, 1);
    // R4: soft reset keeps word and silences pulses
    cyc(8'h04, 0, 4'h0, 32'h0, 1, 1, 1, 1);
    chk("R4 word kept", cfg_rdata, 32'h0000_0140);
    // R10: write at the error edge uses the old word
    cyc(8'h04, 1, 4'hF, 32'h0, 1, 1, 1, 0);
    cyc(8'h04, 0, 4'h0, 32'h0, 1, 1, 1, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = ($urandom % 4 != 0) ? 8'h04 : 8'(($urandom % 64) << 2);
      cyc(a, ($urandom % 3) == 0, 4'($urandom), $urandom,
          ($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom), ($urandom % 16) == 0);
      if (i == 1500) hard_reset();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule